// File: doc/BRIEF.md
# Program/Verify Mode Entry Sequencer

This block lives on the programming host and walks a target device into its serial program/verify mode. A one-cycle start request launches a fixed choreography on three outputs: a target reset request, a serial clock and a serial data line. The reset request is pulsed high and then dropped low. After a guard interval the block shifts out a fixed 32-bit entry key, most significant bit first. It then raises the reset request and keeps it raised, waits a settling interval, and finally asserts ready. A downstream command engine may start sending data only once ready is high.

All intervals are parameters counted in system clock cycles, and every parameter must be at least 1. The session lasts as long as the reset request stays high, which is until abort is asserted. Abort is honoured in any state: it parks every output low and returns the block to idle.

Top module: `prog_entry_seq`

## Requirements
- R1: While rst_n is low, and after it is released with no start, tgt_rst_o, ser_clk_o, ser_dat_o, busy_o and ready_o are all 0.
- R2: A start pulse sampled while idle makes tgt_rst_o and busy_o high from the next cycle on. tgt_rst_o stays high for exactly PULSE_CYC cycles.
- R3: tgt_rst_o then goes low for exactly GUARD_CYC cycles before the first key bit. ser_clk_o and ser_dat_o are 0 during this gap.
- R4: The key 32'h4D434851 goes out on ser_dat_o as 32 bits, bit 31 first. Each bit is HALF_CYC cycles with ser_clk_o low, followed by HALF_CYC cycles with ser_clk_o high.
- R5: ser_dat_o changes only while ser_clk_o is low. It holds its value through every high phase of the clock.
- R6: After the high phase of bit 0, tgt_rst_o goes high with ser_clk_o and ser_dat_o at 0. ready_o stays 0 for exactly HOLD_CYC further cycles and rises after them.
- R7: Once ready, the block holds tgt_rst_o=1, ready_o=1 and busy_o=0 until abort. A start pulse in this state has no effect.
- R8: Abort sampled in any state drives all five outputs to 0 from the next cycle and returns to idle, from which a new start works.
- R9: busy_o is high from the cycle after the accepted start until ready_o rises or abort takes effect, and never together with ready_o.
- R10: A start pulse while busy_o is high is ignored; the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the entry sequence (taken only when idle) |
| abort | input | 1 | Abandon sequence or session, return to idle |
| tgt_rst_o | output | 1 | Target reset request (1 = drive high) |
| ser_clk_o | output | 1 | Serial clock to target |
| ser_dat_o | output | 1 | Serial data to target |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target is in program/verify mode; data may follow |

## Verification
Every output comes from registered state, so a start or abort sampled at one rising edge shows on the outputs during the next cycle. The reset pulse occupies cycles 1 to PULSE_CYC after the start edge, and the following phases come back to back at offsets fixed by the parameters. The bench counts cycles from the start edge and compares all five outputs at each falling edge against a function of that count. It checks abort one cycle after the edge that samples it, and checks the data-hold rule between consecutive samples taken while the clock is high.

// File: rtl/prog_entry_seq.sv
module prog_entry_seq #(
  parameter int PULSE_CYC = 100,
  parameter int GUARD_CYC = 1000,
  parameter int HALF_CYC  = 10,
  parameter int HOLD_CYC  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic tgt_rst_o,
  output logic ser_clk_o,
  output logic ser_dat_o,
  output logic busy_o,
  output logic ready_o
);
  localparam logic [31:0] KEY = 32'h4D434851;
  localparam int M1   = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
  localparam int M2   = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_GAP, S_SHIFT, S_HOLD, S_READY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [4:0]    bidx;
  logic          ph;
  wire           done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= 5'd31;
      ph   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end
        S_PULSE: if (done) begin
          st  <= S_GAP;
          cnt <= CW'(GUARD_CYC - 1);
        end else cnt <= cnt - CW'(1);
        S_GAP: if (done) begin
          st   <= S_SHIFT;
          cnt  <= CW'(HALF_CYC - 1);
          bidx <= 5'd31;
          ph   <= 1'b0;
        end else cnt <= cnt - CW'(1);
        S_SHIFT: if (done) begin
          ph <= ~ph;
          if (ph && bidx == 5'd0) begin
            st  <= S_HOLD;
            cnt <= CW'(HOLD_CYC - 1);
          end else begin
            cnt <= CW'(HALF_CYC - 1);
            if (ph) bidx <= bidx - 5'd1;
          end
        end else cnt <= cnt - CW'(1);
        S_HOLD: if (done) st <= S_READY;
                else cnt <= cnt - CW'(1);
        S_READY: st <= S_READY;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tgt_rst_o = (st == S_PULSE) || (st == S_HOLD) || (st == S_READY);
  assign ser_clk_o = (st == S_SHIFT) && ph;
  assign ser_dat_o = (st == S_SHIFT) && KEY[bidx];
  assign busy_o    = (st != S_IDLE) && (st != S_READY);
  assign ready_o   = (st == S_READY);

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !busy_o && !ready_o) |=> (tgt_rst_o && busy_o));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat_o) |-> !ser_clk_o);
  assert_ready_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (tgt_rst_o && !ser_clk_o && !ser_dat_o));
  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !abort) |=> (ready_o && tgt_rst_o));
  assert_abort_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !(tgt_rst_o || ser_clk_o || ser_dat_o || busy_o || ready_o));
  assert_busy_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ready_o));
endmodule

// File: tb/sim_prog_entry_seq.sv
module sim_prog_entry_seq;
  localparam int P = 3, G = 4, H = 2, HD = 5;
  localparam logic [31:0] KEY = 32'h4D434851;
  localparam int SH_END = P + G + 64 * H;
  localparam int RDY_K  = SH_END + HD + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic tgt_rst_o, ser_clk_o, ser_dat_o, busy_o, ready_o;
  int checks = 0, errors = 0;
  logic prev_clk = 1'b0, prev_dat = 1'b0;

  prog_entry_seq #(.PULSE_CYC(P), .GUARD_CYC(G), .HALF_CYC(H), .HOLD_CYC(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tgt_rst_o(tgt_rst_o), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
    .busy_o(busy_o), .ready_o(ready_o));

  always #5 clk = ~clk;

  // {tgt_rst, ser_clk, ser_dat, busy, ready} at cycle k after the start edge
  function automatic logic [4:0] exp_out(int k);
    int s;
    if (k < 1) return 5'b00000;
    if (k <= P) return 5'b10010;
    if (k <= P + G) return 5'b00010;
    if (k <= SH_END) begin
      s = k - (P + G + 1);
      return {1'b0, (s % (2 * H)) >= H, KEY[31 - s / (2 * H)], 1'b1, 1'b0};
    end
    if (k < RDY_K) return 5'b10010;
    return 5'b10001;
  endfunction

  function automatic string tag_of(int k);
    if (k <= P) return "R2/R9";
    if (k <= P + G) return "R3";
    if (k <= SH_END) return "R4";
    if (k < RDY_K) return "R6";
    return "R7";
  endfunction

  task automatic check(logic [4:0] exp, string tag);
    logic [4:0] act;
    act = {tgt_rst_o, ser_clk_o, ser_dat_o, busy_o, ready_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs act=%b exp=%b", tag, act, exp);
    end
    if (prev_clk && ser_clk_o) begin
      checks++;
      if (ser_dat_o !== prev_dat) begin
        errors++;
        $display("FAIL R5: data moved in high phase act=%b exp=%b", ser_dat_o, prev_dat);
      end
    end
    prev_clk = ser_clk_o;
    prev_dat = ser_dat_o;
  endtask

  // abort_at: cycle index at which abort is driven (0 = run to len then abort)
  task automatic run_seq(int abort_at, int len, bit pokes);
    bit poked;
    int stop;
    stop = (abort_at > 0) ? abort_at : len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    poked = 1'b0;
    for (int k = 1; k <= stop; k++) begin
      check(exp_out(k), poked ? {tag_of(k), " R10"} : tag_of(k));
      poked = 1'b0;
      if (k == stop) abort = 1'b1;
      else if (pokes && ($urandom % 5 == 0)) begin
        start = 1'b1;
        poked = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    abort = 1'b0;
    check(5'b00000, "R8");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(5'b00000, "R8 idle");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(5'b00000, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(5'b00000, "R1 after reset");
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(5'b00000, "R8 abort in idle");
    run_seq(0, RDY_K + 10, 1'b1);
    run_seq(1, 0, 1'b0);
    run_seq(P + G + 1, 0, 1'b0);
    run_seq(60, 0, 1'b1);
    run_seq(SH_END + 2, 0, 1'b0);
    run_seq(0, RDY_K + 3, 1'b0);
    for (int n = 0; n < 8; n++) begin
      int a;
      a = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % (RDY_K + 5));
      run_seq(a, RDY_K + 2 + int'($urandom % 6), 1'b1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule